// File: doc/BRIEF.md
# Synchronous SRAM Read Output Stage

This block is the last stage on the read side of a synchronous burst SRAM. Each cycle it sees the read command that the input registers captured for that cycle, together with the array word for that read, and a deselect command. It drives a data bus that is modelled as a data vector plus a drive-enable flag, so that high-impedance cycles can be seen exactly. When the bus is not driven, the data vector reads as zero.

Two static mode pins shape the timing. The first picks the read latency. In flow-through mode the array word passes straight to the bus. In pipelined mode it goes through a rising-edge output register, which adds one cycle. The second pin picks when a deselect turns the bus off. Single-cycle deselect acts in the same cycle it is captured, one stage ahead of a read. Dual-cycle deselect waits one full cycle, which matches the read pipeline depth. Both pins are sampled only while synchronous reset is high. If both pins are tied low, the block runs pipelined reads with single-cycle deselect. An asynchronous output enable gates the bus at any time.

The bus has no back-pressure. A driven word counts as delivered in the cycle it is shown, and the bus has no ready signal.

Top module: `srp_read_out`

## Requirements
- R1: While reset is high, and in the first cycle after it with no read command, bus_drive is 0 and bus_data is all zeros.
- R2: flow_sel (1 = flow-through, 0 = pipelined) and dual_sel (1 = dual-cycle deselect, 0 = single-cycle) are captured only while rst is 1. Changes after reset have no effect. With both pins tied to 0, the block runs pipelined with single-cycle deselect.
- R3: In pipelined mode, a read captured in cycle c shows its rd_data word on the bus in cycle c+1.
- R4: In flow-through mode, a read captured in cycle c shows its rd_data word on the bus in cycle c itself, without waiting for a clock edge.
- R5: In single-cycle deselect mode, a deselect with no read in cycle c forces the bus off in cycle c. The bus stays off until the next read takes effect.
- R6: In dual-cycle deselect mode, a deselect with no read in cycle c leaves the bus as it was in cycle c. The bus is off from cycle c+1 until the next read takes effect.
- R7: A read issued in the cycle right after a deselect drives its word in its normal cycle (c for flow-through, c+1 for pipelined), even while the earlier deselect is still taking effect.
- R8: When oe is 0, bus_drive is 0 and bus_data is zero at once, whatever the clock is doing. Restoring oe shows the stored bus state again.
- R9: A read and a deselect in the same cycle act as a read. The deselect is ignored.
- R10: In a cycle with neither read nor deselect, the bus keeps the drive state and the word of the previous cycle. rd_data is ignored in such cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge active |
| rst | input | 1 | Synchronous reset, active high; mode pins are sampled while it is high |
| flow_sel | input | 1 | 1 selects flow-through reads, 0 selects pipelined reads |
| dual_sel | input | 1 | 1 selects dual-cycle deselect, 0 selects single-cycle deselect |
| oe | input | 1 | Asynchronous output enable, active high |
| rd_en | input | 1 | Registered read command for the current cycle |
| rd_data | input | DW | Array word for the current cycle's read |
| desel | input | 1 | Registered deselect command for the current cycle |
| bus_drive | output | 1 | 1 when the bus is driven, 0 when it is high impedance |
| bus_data | output | DW | Bus word; all zeros when not driven |

## Verification
The bench runs the same command pattern in all four mode combinations, and changes the mode pins after reset to show they are ignored. A design that latched the modes at the wrong time would switch latency partway through a run. The bench also aims at the exact turn-off cycle after a deselect. A design that mixed up single- and dual-cycle deselect would show the old word one cycle too long or drop it one cycle early. Other targeted cases are a read right after a deselect, a read and a deselect in the same cycle, and output-enable toggling with no clock edge in between. A design that gave the deselect priority, or that gated the enable through a register, would show a wrong drive flag in exactly those cycles.

// File: rtl/srp_pkg.sv
package srp_pkg;
  typedef struct packed {
    logic flow;  // 1: flow-through, 0: pipelined
    logic dual;  // 1: dual-cycle deselect, 0: single-cycle
  } srp_mode_t;
endpackage

// File: rtl/srp_mode_latch.sv
module srp_mode_latch
  import srp_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      flow_in,
  input  logic      dual_in,
  output srp_mode_t mode
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode.flow <= flow_in;
      mode.dual <= dual_in;
    end
  end

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(mode)); // R2
endmodule

// File: rtl/srp_hold_reg.sv
module srp_hold_reg #(
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic          desel,
  input  logic [DW-1:0] rd_data,
  output logic          drv_q,
  output logic [DW-1:0] data_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      drv_q  <= 1'b0;
      data_q <= '0;
    end else if (rd_en) begin
      drv_q  <= 1'b1;
      data_q <= rd_data;
    end else if (desel) begin
      drv_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/srp_out_mux.sv
module srp_out_mux
  import srp_pkg::*;
#(
  parameter int DW = 18
) (
  input  srp_mode_t     mode,
  input  logic          oe,
  input  logic          rd_en,
  input  logic          desel,
  input  logic [DW-1:0] rd_data,
  input  logic          drv_q,
  input  logic [DW-1:0] data_q,
  output logic          bus_drive,
  output logic [DW-1:0] bus_data
);
  logic          desel_only;
  logic          kill_now;
  logic          live;
  logic [DW-1:0] word;

  always_comb begin
    desel_only = desel & ~rd_en;
    kill_now   = ~mode.dual & desel_only;
    if (mode.flow) begin
      live = rd_en | (drv_q & ~kill_now);
      word = rd_en ? rd_data : data_q;
    end else begin
      live = drv_q & ~kill_now;
      word = data_q;
    end
    bus_drive = oe & live;
    bus_data  = bus_drive ? word : '0;
  end

  always_comb begin
    AST_OE_GATE: assert (oe || (!bus_drive && bus_data == '0)); // R8
  end
endmodule

// File: rtl/srp_read_out.sv
module srp_read_out
  import srp_pkg::*;
#(
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flow_sel,
  input  logic          dual_sel,
  input  logic          oe,
  input  logic          rd_en,
  input  logic [DW-1:0] rd_data,
  input  logic          desel,
  output logic          bus_drive,
  output logic [DW-1:0] bus_data
);
  srp_mode_t     mode;
  logic          drv_q;
  logic [DW-1:0] data_q;

  srp_mode_latch u_mode (
    .clk(clk), .rst(rst), .flow_in(flow_sel), .dual_in(dual_sel), .mode(mode)
  );

  srp_hold_reg #(.DW(DW)) u_hold (
    .clk(clk), .rst(rst), .rd_en(rd_en), .desel(desel), .rd_data(rd_data),
    .drv_q(drv_q), .data_q(data_q)
  );

  srp_out_mux #(.DW(DW)) u_mux (
    .mode(mode), .oe(oe), .rd_en(rd_en), .desel(desel), .rd_data(rd_data),
    .drv_q(drv_q), .data_q(data_q), .bus_drive(bus_drive), .bus_data(bus_data)
  );

  AST_PIPE_DATA: assert property (@(posedge clk) disable iff (rst)
    (!mode.flow && !$past(rst) && $past(rd_en) && oe &&
     !(!mode.dual && desel && !rd_en))
    |-> (bus_drive && bus_data == $past(rd_data))); // R3

  AST_FLOW_DATA: assert property (@(posedge clk) disable iff (rst)
    (mode.flow && rd_en && oe) |-> (bus_drive && bus_data == rd_data)); // R4

  AST_SCD_OFF: assert property (@(posedge clk) disable iff (rst)
    (!mode.dual && desel && !rd_en) |-> !bus_drive); // R5

  AST_DCD_OFF: assert property (@(posedge clk) disable iff (rst)
    (mode.dual && !$past(rst) && $past(desel && !rd_en) && !(mode.flow && rd_en))
    |-> !bus_drive); // R6
endmodule

// File: tb/srp_read_out_test.sv
module srp_read_out_test;
  localparam int DW = 18;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          flow_sel = 1'b0;
  logic          dual_sel = 1'b0;
  logic          oe = 1'b1;
  logic          rd_en = 1'b0;
  logic [DW-1:0] rd_data = '0;
  logic          desel = 1'b0;
  logic          bus_drive;
  logic [DW-1:0] bus_data;

  srp_read_out #(.DW(DW)) uut (
    .clk(clk), .rst(rst), .flow_sel(flow_sel), .dual_sel(dual_sel), .oe(oe),
    .rd_en(rd_en), .rd_data(rd_data), .desel(desel),
    .bus_drive(bus_drive), .bus_data(bus_data)
  );

  always #5 clk = ~clk;

  int vectors = 0;
  int fails   = 0;
  int dval    = 1234;

  // Behavioural history of commands since the last reset
  bit            h_rd [0:255];
  bit            h_ds [0:255];
  logic [DW-1:0] h_dat[0:255];
  int            nh = 0;
  bit            m_flow = 1'b0;
  bit            m_dual = 1'b0;

  task automatic check(input bit exp_drv, input logic [DW-1:0] exp_dat, input string tag);
    vectors++;
    if (bus_drive !== exp_drv || bus_data !== exp_dat) begin
      fails++;
      $display("FAIL %s: drive=%0b data=%h expected drive=%0b data=%h (flow=%0b dual=%0b cycle=%0d)",
               tag, bus_drive, bus_data, exp_drv, exp_dat, m_flow, m_dual, nh);
    end
  endtask

  task automatic do_reset(input bit f, input bit d);
    @(negedge clk);
    rst = 1'b1; rd_en = 1'b0; desel = 1'b0; oe = 1'b1;
    flow_sel = f; dual_sel = d;
    @(negedge clk);
    @(negedge clk);
    #1;
    check(1'b0, '0, "R1 during reset");
    m_flow = f; m_dual = d; nh = 0;
    rst = 1'b0;
    // R2: pins change after reset; must be ignored
    flow_sel = ~f; dual_sel = ~d;
  endtask

  // Apply one cycle of stimulus and compare against the history model
  task automatic step(input bit r, input bit d, input bit o, input string tag);
    int k;
    bit drv;
    logic [DW-1:0] exp;
    @(negedge clk);
    dval = (dval * 13 + 7) % 262144;
    rd_en = r; desel = d; oe = o; rd_data = DW'(dval);
    h_rd[nh] = r; h_ds[nh] = d; h_dat[nh] = DW'(dval);
    nh++;
    #1;
    k = -1;
    for (int i = nh - 1; i >= 0; i--) begin
      if (h_rd[i] && (m_flow || i < nh - 1)) begin k = i; break; end
    end
    drv = (k >= 0);
    if (drv) begin
      for (int j = k + 1; j <= (m_dual ? nh - 2 : nh - 1); j++) begin
        if (h_ds[j] && !h_rd[j]) drv = 1'b0;
      end
    end
    drv = drv & o;
    exp = drv ? h_dat[k] : '0;
    check(drv, exp, tag);
  endtask

  task automatic run_pattern();
    step(0, 0, 1, "R1 idle after reset");
    step(1, 0, 1, "R3/R4 first read");
    step(0, 0, 1, "R10 idle hold");
    step(1, 0, 1, "R3/R4 second read");
    step(1, 0, 1, "R3/R4 back-to-back read");
    step(0, 1, 1, "R5/R6 deselect");
    step(0, 0, 1, "R5/R6 after deselect");
    step(0, 0, 1, "R10 idle while off");
    step(1, 0, 1, "R3 read from off");
    step(0, 1, 1, "R5/R6 deselect before read");
    step(1, 0, 1, "R7 read right after deselect");
    step(0, 0, 1, "R7 following cycle");
    step(1, 1, 1, "R9 read with deselect");
    step(0, 0, 1, "R9 following cycle");
    step(1, 0, 0, "R8 read with oe low");
    step(0, 0, 0, "R8 oe low idle");
    step(0, 0, 1, "R8 oe restored");
    step(0, 1, 0, "R8 deselect with oe low");
    step(0, 0, 1, "R8 restored after deselect");
  endtask

  initial begin
    // R2: default tie-low pins give pipelined single-cycle deselect
    do_reset(1'b0, 1'b0);
    run_pattern();
    do_reset(1'b0, 1'b1);
    run_pattern();
    do_reset(1'b1, 1'b0);
    run_pattern();
    do_reset(1'b1, 1'b1);
    run_pattern();
    // R8: oe dropped between clock edges acts at once
    @(negedge clk);
    rd_en = 1'b0; desel = 1'b0; oe = 1'b1;
    #2;
    oe = 1'b0;
    #1;
    vectors++;
    if (bus_drive !== 1'b0 || bus_data !== '0) begin
      fails++;
      $display("FAIL R8 async oe: drive=%0b data=%h expected drive=0 data=0", bus_drive, bus_data);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule